// File: doc/BRIEF.md
# Eight-Character Display Buffer

This block holds the eight characters shown on a small text display and exposes them to a processor bus through an eight-byte window. An access names a starting byte offset and a byte count of one, two, four or eight. A write distributes the bus bytes over the buffer. A read collects buffer bytes onto the bus. Offsets wrap modulo eight, so a wide access that starts part-way into the window continues at entry zero. It is never split and never faults.

Each accepted write makes the block emit a one-cycle refresh strobe. Alongside the strobe it presents a parallel copy of all eight characters, so that a downstream display driver can redraw the whole line. When the display link comes up for the first time after reset, the buffer is cleared to spaces and a refresh is issued. Any later link-up is ignored.

Top module: `charbuf8`

## Requirements
- R1: After synchronous reset every buffer entry holds 0x20 (space), `refresh` is low and `snapshot` is zero.
- R2: `acc_bytes` carries the byte count. Only the values 1, 2, 4 and 8 are accepted. A write with any other value changes no entry and raises no refresh, and a read with any other value returns zero.
- R3: For a read of N bytes at offset A, bus byte k (bits 8k+7..8k, k < N) carries buffer entry (A+k) mod 8. Bus bytes k >= N read as zero. `rd_data` follows `addr` and `acc_bytes` without a clock.
- R4: For a write of N bytes at offset A, bus byte k (k < N) is stored in entry (A+k) mod 8. All other entries keep their value.
- R5: An access whose bytes run past entry 7 continues at entry 0, for both reads and writes.
- R6: A write accepted on clock edge T is readable right after T. `refresh` is then high for exactly the one cycle between edges T+1 and T+2.
- R7: While `refresh` is high, `snapshot` holds every entry, with entry e in bits 8e+7..8e. While `refresh` is low, `snapshot` is zero.
- R8: The first rising edge of `link_up` after reset fills all entries with 0x20 and raises `refresh` with the same timing as a write. Later rising edges change nothing and raise no refresh.
- R9: A write accepted on the same edge as the first link-up is applied on top of the fill. The written entries take the write data, the rest become spaces, and exactly one refresh follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request, sampled on the rising edge |
| addr | input | 3 | Starting byte offset within the window |
| acc_bytes | input | 4 | Access size in bytes (1, 2, 4 or 8 valid) |
| wr_data | input | 64 | Write data, byte 0 in bits 7..0 |
| rd_data | output | 64 | Read data for the current `addr` and `acc_bytes` |
| link_up | input | 1 | Display link state; its first rise triggers the clear |
| refresh | output | 1 | One-cycle redraw strobe |
| snapshot | output | 64 | All eight characters while `refresh` is high |

## Verification
The bench targets wrapped accesses, for example four bytes at offset 6 and eight bytes at offset 7. A design that clamps or splits instead of wrapping would read or write the wrong entries there. It issues writes with sizes 3 and 0: a design that decodes the count loosely would modify entries or raise a strobe. It raises the link twice: a design without the one-time latch would wipe text on the second rise. It also writes on the same edge as the first link-up: a design that gives the fill or the write exclusive priority would lose either the spaces or the data. Strobe timing is sampled cycle by cycle, so a strobe that is early, late or two cycles long is caught.

// File: rtl/charbuf8_pkg.sv
// Package: shared constants for the eight-character display buffer.
// Assumes characters are byte-wide codes in which 0x20 is a space.
package charbuf8_pkg;
    localparam int unsigned CB_DEF_ENTRIES = 8;
    localparam int unsigned CB_DEF_CHAR_W  = 8;
    localparam logic [7:0]  CB_FILL_CHAR   = 8'h20;
endpackage

// File: rtl/cb8_size_dec.sv
// Size decoder: checks the byte count of an access and turns it into a
// per-lane enable. Assumes ENTRIES is a power of two.
module cb8_size_dec #(
    parameter  int ENTRIES = 8,
    localparam int CNT_W   = $clog2(ENTRIES) + 1
) (
    input  logic [CNT_W-1:0]   acc_bytes,
    output logic               size_ok,
    output logic [ENTRIES-1:0] lane_en
);
    // Accept a nonzero power of two no larger than the window.
    always_comb begin
        size_ok = (acc_bytes != '0)
               && ((acc_bytes & (acc_bytes - 1'b1)) == '0)
               && (acc_bytes <= CNT_W'(ENTRIES));
    end

    // Lane k is live when the access is legal and k is below the count.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_lane
        assign lane_en[k] = size_ok && (CNT_W'(k) < acc_bytes);
    end
endmodule

// File: rtl/cb8_lane_map.sv
// Lane mapper: rotates bus byte lanes to buffer entries modulo the
// window size, for both the read gather and the write scatter.
// Assumes ENTRIES is a power of two, so the offset sum wraps by itself.
module cb8_lane_map #(
    parameter  int ENTRIES = 8,
    parameter  int CHAR_W  = 8,
    localparam int AW      = $clog2(ENTRIES),
    localparam int DW      = ENTRIES * CHAR_W
) (
    input  logic [AW-1:0]      addr,
    input  logic [ENTRIES-1:0] lane_en,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW-1:0]      buf_flat,
    output logic [DW-1:0]      rd_data,
    output logic [ENTRIES-1:0] ent_we,
    output logic [DW-1:0]      ent_wdata
);
    // Read gather: lane k takes entry (addr+k) mod ENTRIES.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_rd
        logic [AW-1:0] src_idx;
        assign src_idx = addr + AW'(k);
        assign rd_data[k*CHAR_W +: CHAR_W] =
            lane_en[k] ? buf_flat[src_idx*CHAR_W +: CHAR_W] : '0;
    end

    // Write scatter: entry e is fed by lane (e-addr) mod ENTRIES.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_wr
        logic [AW-1:0] lane_idx;
        assign lane_idx = AW'(e) - addr;
        assign ent_we[e] = lane_en[lane_idx];
        assign ent_wdata[e*CHAR_W +: CHAR_W] = wr_data[lane_idx*CHAR_W +: CHAR_W];
    end
endmodule

// File: rtl/cb8_store.sv
// Character store: the ENTRIES registers of the buffer. A fill request
// loads spaces everywhere and a write on the same edge overlays it.
module cb8_store #(
    parameter  int         ENTRIES = 8,
    parameter  int         CHAR_W  = 8,
    parameter  logic [7:0] FILL    = 8'h20,
    localparam int         DW      = ENTRIES * CHAR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill,
    input  logic               wr_commit,
    input  logic [ENTRIES-1:0] ent_we,
    input  logic [DW-1:0]      ent_wdata,
    output logic [DW-1:0]      buf_flat
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [CHAR_W-1:0] ch_q;
        logic [CHAR_W-1:0] ch_d;

        // Next value: a write wins over the fill, the fill wins over hold.
        always_comb begin
            ch_d = fill ? CHAR_W'(FILL) : ch_q;
            if (wr_commit && ent_we[e]) begin
                ch_d = ent_wdata[e*CHAR_W +: CHAR_W];
            end
        end

        // Entry register, reset to a space.
        always_ff @(posedge clk) begin
            if (!rst_n) ch_q <= CHAR_W'(FILL);
            else        ch_q <= ch_d;
        end

        assign buf_flat[e*CHAR_W +: CHAR_W] = ch_q;
    end
endmodule

// File: rtl/cb8_refresh.sv
// Refresh control: detects the first link-up after reset, and turns each
// buffer change into a one-cycle strobe delayed by one cycle, with a
// parallel copy of the buffer presented during the strobe.
module cb8_refresh #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          wr_commit,
    input  logic [DW-1:0] buf_flat,
    output logic          init_fire,
    output logic          refresh,
    output logic [DW-1:0] snapshot
);
    logic          link_q;
    logic          init_done_q;
    logic          change_q;
    logic          refresh_q;
    logic [DW-1:0] snap_q;

    // First rising edge of the link since reset.
    assign init_fire = link_up && !link_q && !init_done_q;

    // Link edge history and the one-time latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q      <= 1'b0;
            init_done_q <= 1'b0;
        end else begin
            link_q <= link_up;
            if (init_fire) init_done_q <= 1'b1;
        end
    end

    // Strobe pipeline: the change is noted, then the strobe and copy follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            change_q  <= 1'b0;
            refresh_q <= 1'b0;
            snap_q    <= '0;
        end else begin
            change_q  <= wr_commit || init_fire;
            refresh_q <= change_q;
            if (change_q) snap_q <= buf_flat;
        end
    end

    assign refresh  = refresh_q;
    assign snapshot = refresh_q ? snap_q : '0;
endmodule

// File: rtl/charbuf8.sv
// Top: memory-mapped eight-character display buffer with wrapping
// byte-lane access, a redraw strobe and a one-time clear on link-up.
// Assumes a single clock domain and a link_up input already synchronised.
module charbuf8
    import charbuf8_pkg::*;
#(
    parameter  int NUM_BYTES = CB_DEF_ENTRIES,
    parameter  int BYTE_W    = CB_DEF_CHAR_W,
    localparam int AW        = $clog2(NUM_BYTES),
    localparam int CNT_W     = AW + 1,
    localparam int DW        = NUM_BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [CNT_W-1:0] acc_bytes,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             link_up,
    output logic             refresh,
    output logic [DW-1:0]    snapshot
);
    logic                 size_ok;
    logic [NUM_BYTES-1:0] lane_en;
    logic [NUM_BYTES-1:0] ent_we;
    logic [DW-1:0]        ent_wdata;
    logic [DW-1:0]        buf_flat;
    logic                 init_fire;
    logic                 wr_commit;

    // A write counts only when its size is legal.
    assign wr_commit = wr_en && size_ok;

    cb8_size_dec #(.ENTRIES(NUM_BYTES)) u_size (
        .acc_bytes (acc_bytes),
        .size_ok   (size_ok),
        .lane_en   (lane_en)
    );

    cb8_lane_map #(.ENTRIES(NUM_BYTES), .CHAR_W(BYTE_W)) u_map (
        .addr      (addr),
        .lane_en   (lane_en),
        .wr_data   (wr_data),
        .buf_flat  (buf_flat),
        .rd_data   (rd_data),
        .ent_we    (ent_we),
        .ent_wdata (ent_wdata)
    );

    cb8_store #(.ENTRIES(NUM_BYTES), .CHAR_W(BYTE_W), .FILL(CB_FILL_CHAR)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (init_fire),
        .wr_commit (wr_commit),
        .ent_we    (ent_we),
        .ent_wdata (ent_wdata),
        .buf_flat  (buf_flat)
    );

    cb8_refresh #(.DW(DW)) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .wr_commit (wr_commit),
        .buf_flat  (buf_flat),
        .init_fire (init_fire),
        .refresh   (refresh),
        .snapshot  (snapshot)
    );
endmodule

// File: rtl/charbuf8_chk.sv
// Checker: temporal properties of the display buffer, bound to the top.
module charbuf8_chk
    import charbuf8_pkg::*;
#(
    parameter  int NUM_BYTES = 8,
    parameter  int BYTE_W    = 8,
    localparam int AW        = $clog2(NUM_BYTES),
    localparam int CNT_W     = AW + 1,
    localparam int DW        = NUM_BYTES * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CNT_W-1:0] acc_bytes,
    input logic [DW-1:0]    rd_data,
    input logic             refresh,
    input logic [DW-1:0]    snapshot,
    input logic [DW-1:0]    buf_flat,
    input logic             init_fire
);
    logic legal;
    logic trig;
    logic init_seen_q;

    // Independent legality check of the byte count.
    always_comb begin
        legal = 1'b0;
        for (int n = 1; n <= NUM_BYTES; n = n * 2) begin
            if (acc_bytes == CNT_W'(n)) legal = 1'b1;
        end
    end

    assign trig = (wr_en && legal) || init_fire;

    // Remember that the one-time clear has happened.
    always_ff @(posedge clk) begin
        if (!rst_n)         init_seen_q <= 1'b0;
        else if (init_fire) init_seen_q <= 1'b1;
    end

    AST_RESET_SPACES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (buf_flat == {NUM_BYTES{BYTE_W'(CB_FILL_CHAR)}})); // R1
    AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal && !init_fire) |=> $stable(buf_flat)); // R2
    AST_BAD_SIZE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> (rd_data == '0)); // R2
    AST_SINGLE_LANE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_bytes == CNT_W'(1)) |-> (rd_data[DW-1:BYTE_W] == '0)); // R3
    AST_REFRESH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> $past(trig, 2)); // R6
    AST_REFRESH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> ##2 refresh); // R6
    AST_SNAP_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |-> (snapshot == '0)); // R7
    AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        init_seen_q |-> !init_fire); // R8
endmodule

bind charbuf8 charbuf8_chk #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .acc_bytes (acc_bytes),
    .rd_data   (rd_data),
    .refresh   (refresh),
    .snapshot  (snapshot),
    .buf_flat  (buf_flat),
    .init_fire (init_fire)
);

// File: tb/charbuf8_test.sv
module charbuf8_test;
    typedef struct packed {
        logic        is_wr;
        logic [2:0]  a;
        logic [3:0]  n;
        logic [63:0] d;
    } op_t;

    localparam int NOPS = 16;
    localparam op_t OPS [NOPS] = '{
        '{1'b1, 3'd0, 4'd8, 64'h4746454443424140},  // R4 full write
        '{1'b0, 3'd0, 4'd8, 64'h0},                 // R3
        '{1'b0, 3'd3, 4'd4, 64'h0},                 // R3
        '{1'b0, 3'd6, 4'd4, 64'h0},                 // R5 read wrap
        '{1'b0, 3'd7, 4'd2, 64'h0},                 // R5
        '{1'b0, 3'd5, 4'd1, 64'h0},                 // R3
        '{1'b1, 3'd6, 4'd4, 64'h00000000DDCCBBAA},  // R5 write wrap
        '{1'b0, 3'd0, 4'd8, 64'h0},                 // R4
        '{1'b1, 3'd3, 4'd2, 64'hFFFFFFFFFFFF1122},  // R4 upper lanes unused
        '{1'b1, 3'd7, 4'd8, 64'h0807060504030201},  // R5
        '{1'b0, 3'd1, 4'd8, 64'h0},                 // R3
        '{1'b0, 3'd4, 4'd2, 64'h0},                 // R3
        '{1'b1, 3'd2, 4'd3, 64'h9999999999999999},  // R2 illegal size
        '{1'b1, 3'd5, 4'd0, 64'h7777777777777777},  // R2 zero size
        '{1'b0, 3'd2, 4'd3, 64'h0},                 // R2 read illegal
        '{1'b0, 3'd0, 4'd8, 64'h0}                  // R2 contents unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  acc_bytes = 4'd8;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        link_up = 1'b0;
    logic        refresh;
    logic [63:0] snapshot;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [8];

    always #10 clk = ~clk;

    charbuf8 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .acc_bytes (acc_bytes),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .link_up   (link_up),
        .refresh   (refresh),
        .snapshot  (snapshot)
    );

    function automatic bit legal(input logic [3:0] n);
        return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
    endfunction

    function automatic logic [63:0] exp_read(input logic [2:0] a, input logic [3:0] n);
        logic [63:0] r = '0;
        if (legal(n)) begin
            for (int k = 0; k < 8; k++) begin
                if (k < int'(n)) r[k*8 +: 8] = mdl[(int'(a) + k) % 8];
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] mdl_flat();
        logic [63:0] r;
        for (int e = 0; e < 8; e++) r[e*8 +: 8] = mdl[e];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mdl_fill();
        for (int e = 0; e < 8; e++) mdl[e] = 8'h20;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; link_up = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_fill();
    endtask

    task automatic do_read(input logic [2:0] a, input logic [3:0] n, input string req);
        @(negedge clk);
        addr = a; acc_bytes = n;
        #2;
        chk(rd_data == exp_read(a, n), req, rd_data, exp_read(a, n));
    endtask

    // Write (optionally with the link rising on the same edge); checks strobe timing.
    task automatic do_write(input logic [2:0] a, input logic [3:0] n, input logic [63:0] d,
                            input bit with_link, input bit link_counts, input string req);
        bit exp_ref;
        @(negedge clk);
        wr_en = 1'b1; addr = a; acc_bytes = n; wr_data = d;
        if (with_link) link_up = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (with_link && link_counts) mdl_fill();
        if (legal(n)) begin
            for (int k = 0; k < 8; k++) begin
                if (k < int'(n)) mdl[(int'(a) + k) % 8] = d[k*8 +: 8];
            end
        end
        exp_ref = legal(n) || (with_link && link_counts);
        chk(refresh == 1'b0, {req, " R6 no early strobe"}, 64'(refresh), 64'd0);
        @(negedge clk);
        chk(refresh == exp_ref, {req, " R6 strobe"}, 64'(refresh), 64'(exp_ref));
        if (exp_ref) chk(snapshot == mdl_flat(), {req, " R7 snapshot"}, snapshot, mdl_flat());
        @(negedge clk);
        chk(refresh == 1'b0, {req, " R6 single cycle"}, 64'(refresh), 64'd0);
        chk(snapshot == '0, {req, " R7 idle zero"}, snapshot, 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        #2;
        chk(refresh == 1'b0, "R1 refresh", 64'(refresh), 64'd0);
        chk(snapshot == '0, "R1 snapshot", snapshot, 64'd0);
        do_read(3'd0, 4'd8, "R1 spaces");

        // Table walk: R2 R3 R4 R5 R6 R7
        foreach (OPS[i]) begin
            if (OPS[i].is_wr) do_write(OPS[i].a, OPS[i].n, OPS[i].d, 1'b0, 1'b0, "R4 table write");
            else              do_read(OPS[i].a, OPS[i].n, "R3 table read");
        end

        // R8: first link-up clears and strobes
        do_write(3'd0, 4'd0, 64'h0, 1'b1, 1'b1, "R8 first link-up");
        do_read(3'd0, 4'd8, "R8 cleared");
        do_write(3'd1, 4'd2, 64'h5A59, 1'b0, 1'b0, "R8 write after clear");
        // R8: second rise is ignored
        @(negedge clk); link_up = 1'b0;
        @(negedge clk);
        do_write(3'd0, 4'd0, 64'h0, 1'b1, 1'b0, "R8 later link-up");
        do_read(3'd0, 4'd8, "R8 text kept");

        // R9: write on the first link-up edge overlays the fill
        do_reset();
        do_write(3'd0, 4'd8, 64'h3132333435363738, 1'b0, 1'b0, "R9 preload");
        do_write(3'd2, 4'd2, 64'h6261, 1'b1, 1'b1, "R9 overlay");
        do_read(3'd0, 4'd8, "R9 overlay contents");

        // R1: reset after activity restores spaces
        do_reset();
        do_read(3'd4, 4'd8, "R1 spaces again");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule